// File: doc/BRIEF.md
# Hexadecimal Floating-Point Adder

This block adds or subtracts two base-16 floating-point numbers. Each operand's top word holds a sign bit, a 7-bit exponent biased by 64, and the leading fraction digits. In the wide format a second word carries more fraction digits. The caller presents both operands and the mode inputs, then pulses `start`. The block captures everything it needs on that edge. It then works one hex digit per clock and pulses `done` when the result is ready.

The datapath keeps one extra hex digit (a guard digit) below the fraction. It aligns the operand with the smaller exponent by shifting it right. When the effective signs differ it subtracts by two's complement, with recomplementation if needed. After the add, the result can optionally be normalized to a nonzero leading digit. Exponent wrap in either direction is reported on two flag outputs. A compare mode produces only the condition code and leaves the stored result alone.

Top module: `hex_fp_adder`

## Requirements
- R1: Operand layout is sign in bit 31, exponent in bits 30:24 (excess 64), and fraction in bits 23:0 of the high word. When `long_fmt` is 1, the low word holds 32 more fraction bits below these. When `long_fmt` is 0, the low input words are ignored and `res_lo` is 0.
- R2: The operand with the smaller exponent is shifted right one hex digit per step until the exponents match. One guard digit below the fraction is kept, and digits shifted past it are lost. The result exponent starts as the larger exponent.
- R3: With equal effective signs, the magnitudes are added and the sign is kept. A carry out of the leading digit shifts the result right one digit and adds 1 to the exponent.
- R4: The effective sign of B is bit 31 of `b_hi` XOR `sub_b`. With unequal effective signs, the magnitude is the difference. The sign is B's effective sign when |B| >= |A|, which includes an exact cancellation to zero; otherwise it is A's sign.
- R5: `cc` is 0 when the result fraction, including the guard digit, is zero. It is 1 when the fraction is nonzero and the sign is negative, and 2 when it is nonzero and positive. It is never 3.
- R6: When `cmp_only` is 1, only `cc` is produced. `res_wr` stays 0, `res_hi`/`res_lo` keep their previous values, and both exponent flags read 0.
- R7: When `norm_en` is 1 and the fraction is nonzero, the result is shifted left one digit at a time, with the exponent decremented each time, until the leading digit is nonzero. With `norm_en` at 0, or with a zero fraction, no left shift happens.
- R8: An exponent increment from 127 wraps to 0 and sets `exp_ovf`. A decrement from 0 wraps to 127 and sets `exp_unf`. The two flags are never both set.
- R9: `start` is accepted only while `busy` is 0, and a `start` during an operation has no effect. Each operation ends with one single-cycle `done` pulse. `res_wr` pulses with `done` for every non-compare operation.
- R10: The stored result fraction is the top fraction digits of the working value; the guard digit is dropped.
- R11: After reset, `busy`, `done`, `res_wr`, `cc`, both flags and both result words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled when idle) |
| long_fmt | input | 1 | 1 selects the two-word format |
| norm_en | input | 1 | 1 normalizes the result |
| cmp_only | input | 1 | 1 produces the condition code only |
| sub_b | input | 1 | 1 inverts the sign of B (subtract) |
| a_hi | input | 32 | Operand A, high word |
| a_lo | input | 32 | Operand A, low fraction word |
| b_hi | input | 32 | Operand B, high word |
| b_lo | input | 32 | Operand B, low fraction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_wr | output | 1 | Result words updated this cycle |
| res_hi | output | 32 | Result high word |
| res_lo | output | 32 | Result low word |
| cc | output | 2 | Condition code |
| exp_ovf | output | 1 | Exponent overflow seen |
| exp_unf | output | 1 | Exponent underflow seen |

## Verification
The embedded properties are checked on every cycle:
- `done` is a single-cycle pulse.
- `res_wr` never appears in compare mode.
- Exponents are equal when the add step runs.
- `cc` never takes the value 3, and the two exponent flags are exclusive.
- Narrow-format results have a zero low word.
- A normalized nonzero result has a nonzero leading digit.
- The captured signs stay fixed while alignment runs.

Only the bench scenarios can show that the values themselves are right:
- the arithmetic result words and the recomplemented sign;
- guard-digit truncation;
- the wrap values on overflow and underflow;
- that a `start` issued while busy leaves the result untouched.

// File: rtl/hfa_pkg.sv
package hfa_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALIGN = 2'd1,
      ST_ADD   = 2'd2,
      ST_NORM  = 2'd3
   } hfa_state_e;

   localparam logic [1:0] CC_ZERO = 2'd0;
   localparam logic [1:0] CC_NEG  = 2'd1;
   localparam logic [1:0] CC_POS  = 2'd2;

endpackage

// File: rtl/hfa_align.sv
module hfa_align #(
   parameter int WK_W  = 64,
   parameter int EXP_W = 7
) (
   input  logic [WK_W-1:0]  fa,
   input  logic [WK_W-1:0]  fb,
   input  logic [EXP_W-1:0] ea,
   input  logic [EXP_W-1:0] eb,
   input  logic [WK_W-1:0]  keep_mask,
   output logic [WK_W-1:0]  fa_n,
   output logic [WK_W-1:0]  fb_n,
   output logic [EXP_W-1:0] ea_n,
   output logic [EXP_W-1:0] eb_n,
   output logic             matched
);
   localparam logic [EXP_W-1:0] ONE = {{(EXP_W-1){1'b0}}, 1'b1};

   always_comb begin
      fa_n    = fa;
      fb_n    = fb;
      ea_n    = ea;
      eb_n    = eb;
      matched = (ea == eb);
      if (ea > eb) begin
         fb_n = (fb >> 4) & keep_mask;
         eb_n = eb + ONE;
      end else if (eb > ea) begin
         fa_n = (fa >> 4) & keep_mask;
         ea_n = ea + ONE;
      end
   end
endmodule

// File: rtl/hfa_addsub.sv
module hfa_addsub #(
   parameter int WK_W = 64
) (
   input  logic [WK_W-1:0] fa,
   input  logic [WK_W-1:0] fb,
   input  logic            sa,
   input  logic            sb,
   output logic [WK_W-1:0] sum,
   output logic            sign
);
   localparam int MAG_W = WK_W - 4;
   localparam logic [MAG_W:0]   ONE_X = {{MAG_W{1'b0}}, 1'b1};
   localparam logic [MAG_W-1:0] ONE_M = {{(MAG_W-1){1'b0}}, 1'b1};

   logic [MAG_W:0] like_sum;
   logic [MAG_W:0] cmpl_sum;

   always_comb begin
      like_sum = {1'b0, fa[MAG_W-1:0]} + {1'b0, fb[MAG_W-1:0]};
      cmpl_sum = {1'b0, fb[MAG_W-1:0]} + {1'b0, ~fa[MAG_W-1:0]} + ONE_X;
      if (sa == sb) begin
         sum  = {3'b000, like_sum};
         sign = sa;
      end else if (cmpl_sum[MAG_W]) begin
         sum  = {4'b0000, cmpl_sum[MAG_W-1:0]};
         sign = sb;
      end else begin
         sum  = {4'b0000, ~cmpl_sum[MAG_W-1:0] + ONE_M};
         sign = sa;
      end
   end
endmodule

// File: rtl/hfa_norm.sv
module hfa_norm #(
   parameter int WK_W  = 64,
   parameter int EXP_W = 7
) (
   input  logic [WK_W-1:0]  fr,
   input  logic [EXP_W-1:0] ex,
   input  logic             norm_on,
   input  logic [WK_W-1:0]  keep_mask,
   output logic [WK_W-1:0]  fr_n,
   output logic [EXP_W-1:0] ex_n,
   output logic             ovf_step,
   output logic             unf_step,
   output logic             settled
);
   localparam logic [EXP_W-1:0] ONE = {{(EXP_W-1){1'b0}}, 1'b1};

   logic carry_dig;
   logic lead_zero;

   always_comb begin
      carry_dig = |fr[WK_W-1 -: 4];
      lead_zero = (fr[WK_W-5 -: 4] == 4'h0);
      fr_n      = fr;
      ex_n      = ex;
      ovf_step  = 1'b0;
      unf_step  = 1'b0;
      settled   = 1'b0;
      if (carry_dig) begin
         fr_n     = (fr >> 4) & keep_mask;
         ex_n     = ex + ONE;
         ovf_step = &ex;
      end else if (norm_on && (|fr) && lead_zero) begin
         fr_n     = (fr << 4) & keep_mask;
         ex_n     = ex - ONE;
         unf_step = (ex == '0);
      end else begin
         settled  = 1'b1;
      end
   end
endmodule

// File: rtl/hex_fp_adder.sv
module hex_fp_adder #(
   parameter int WORD_W  = 32,
   parameter int EXP_W   = 7,
   parameter bit LONG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              long_fmt,
   input  logic              norm_en,
   input  logic              cmp_only,
   input  logic              sub_b,
   input  logic [WORD_W-1:0] a_hi,
   input  logic [WORD_W-1:0] a_lo,
   input  logic [WORD_W-1:0] b_hi,
   input  logic [WORD_W-1:0] b_lo,
   output logic              busy,
   output logic              done,
   output logic              res_wr,
   output logic [WORD_W-1:0] res_hi,
   output logic [WORD_W-1:0] res_lo,
   output logic [1:0]        cc,
   output logic              exp_ovf,
   output logic              exp_unf
);
   import hfa_pkg::*;

   localparam int FRAC_S = WORD_W - 1 - EXP_W;
   localparam int FRAC_L = FRAC_S + WORD_W;
   localparam int WK_W   = FRAC_L + 8;
   localparam int MAG_W  = WK_W - 4;
   localparam logic [WK_W-1:0] MASK_LONG  = {WK_W{1'b1}};
   localparam logic [WK_W-1:0] MASK_SHORT =
      {{(FRAC_S + 8){1'b1}}, {(WK_W - FRAC_S - 8){1'b0}}};

   if ((FRAC_S % 4) != 0 || (WORD_W % 4) != 0 || FRAC_S < 4) begin : g_bad_cfg
      $error("hex_fp_adder: fraction fields must be whole hex digits");
   end

   hfa_state_e       state_q;
   logic [WK_W-1:0]  fa_q, fb_q, fr_q;
   logic [EXP_W-1:0] ea_q, eb_q, er_q;
   logic             sa_q, sb_q, sr_q;
   logic             long_q, norm_q, cmp_q;
   logic             ovf_acc, unf_acc;
   logic [WK_W-1:0]  keep_mask;
   logic             long_in;
   logic [WORD_W-1:0] a_low_sel, b_low_sel;

   if (LONG_EN) begin : g_long
      assign long_in   = long_fmt;
      assign keep_mask = long_q ? MASK_LONG : MASK_SHORT;
   end else begin : g_short
      assign long_in   = 1'b0;
      assign keep_mask = MASK_SHORT;
   end

   assign a_low_sel = long_in ? a_lo : '0;
   assign b_low_sel = long_in ? b_lo : '0;

   logic [WK_W-1:0]  fa_n, fb_n;
   logic [EXP_W-1:0] ea_n, eb_n;
   logic             matched;

   hfa_align #(.WK_W(WK_W), .EXP_W(EXP_W)) u_align (
      .fa(fa_q), .fb(fb_q), .ea(ea_q), .eb(eb_q), .keep_mask(keep_mask),
      .fa_n(fa_n), .fb_n(fb_n), .ea_n(ea_n), .eb_n(eb_n), .matched(matched)
   );

   logic [WK_W-1:0] sum_w;
   logic            sign_w;

   hfa_addsub #(.WK_W(WK_W)) u_addsub (
      .fa(fa_q), .fb(fb_q), .sa(sa_q), .sb(sb_q), .sum(sum_w), .sign(sign_w)
   );

   logic [WK_W-1:0]  fr_n;
   logic [EXP_W-1:0] er_n;
   logic             ovf_step, unf_step, settled;

   hfa_norm #(.WK_W(WK_W), .EXP_W(EXP_W)) u_norm (
      .fr(fr_q), .ex(er_q), .norm_on(norm_q), .keep_mask(keep_mask),
      .fr_n(fr_n), .ex_n(er_n), .ovf_step(ovf_step), .unf_step(unf_step),
      .settled(settled)
   );

   assign busy = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fa_q    <= '0;
         fb_q    <= '0;
         fr_q    <= '0;
         ea_q    <= '0;
         eb_q    <= '0;
         er_q    <= '0;
         sa_q    <= 1'b0;
         sb_q    <= 1'b0;
         sr_q    <= 1'b0;
         long_q  <= 1'b0;
         norm_q  <= 1'b0;
         cmp_q   <= 1'b0;
         ovf_acc <= 1'b0;
         unf_acc <= 1'b0;
         done    <= 1'b0;
         res_wr  <= 1'b0;
         res_hi  <= '0;
         res_lo  <= '0;
         cc      <= CC_ZERO;
         exp_ovf <= 1'b0;
         exp_unf <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               done   <= 1'b0;
               res_wr <= 1'b0;
               if (start) begin
                  fa_q    <= {4'h0, a_hi[FRAC_S-1:0], a_low_sel, 4'h0};
                  fb_q    <= {4'h0, b_hi[FRAC_S-1:0], b_low_sel, 4'h0};
                  ea_q    <= a_hi[WORD_W-2 -: EXP_W];
                  eb_q    <= b_hi[WORD_W-2 -: EXP_W];
                  sa_q    <= a_hi[WORD_W-1];
                  sb_q    <= b_hi[WORD_W-1] ^ sub_b;
                  long_q  <= long_in;
                  norm_q  <= norm_en;
                  cmp_q   <= cmp_only;
                  state_q <= ST_ALIGN;
               end
            end
            ST_ALIGN: begin
               if (matched) begin
                  state_q <= ST_ADD;
               end else begin
                  fa_q <= fa_n;
                  fb_q <= fb_n;
                  ea_q <= ea_n;
                  eb_q <= eb_n;
               end
            end
            ST_ADD: begin
               fr_q    <= sum_w;
               sr_q    <= sign_w;
               er_q    <= ea_q;
               ovf_acc <= 1'b0;
               unf_acc <= 1'b0;
               if (sum_w == '0) cc <= CC_ZERO;
               else             cc <= sign_w ? CC_NEG : CC_POS;
               if (cmp_q) begin
                  done    <= 1'b1;
                  exp_ovf <= 1'b0;
                  exp_unf <= 1'b0;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_NORM;
               end
            end
            ST_NORM: begin
               if (settled) begin
                  res_hi  <= {sr_q, er_q, fr_q[MAG_W-1 -: FRAC_S]};
                  res_lo  <= long_q ? fr_q[MAG_W-1-FRAC_S -: WORD_W] : '0;
                  exp_ovf <= ovf_acc;
                  exp_unf <= unf_acc;
                  done    <= 1'b1;
                  res_wr  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  fr_q    <= fr_n;
                  er_q    <= er_n;
                  ovf_acc <= ovf_acc | ovf_step;
                  unf_acc <= unf_acc | unf_step;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9: completion is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: captured signs stay put while alignment runs, whatever start does
   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ALIGN) |=> $stable(sa_q) && $stable(sb_q) && $stable(cmp_q));

   // R6: no result write in compare mode, and writes only with done
   assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_wr |-> (done && !cmp_q));

   // R2: add step only runs on matched exponents
   assert_aligned_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADD) |-> (ea_q == eb_q));

   // R5: condition code never takes the value 3
   assert_cc_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cc != 2'b11);

   // R8: overflow and underflow are exclusive
   assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exp_ovf, exp_unf}));

   // R1: narrow results have a zero low word
   assert_short_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (res_wr && !long_q) |-> (res_lo == '0));

   // R7: a normalized nonzero result leads with a nonzero digit
   assert_norm_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_wr && norm_q && cc != CC_ZERO) |-> (res_hi[FRAC_S-1 -: 4] != 4'h0));

endmodule

// File: tb/hex_fp_adder_tb.sv
`timescale 1ns/1ps
module hex_fp_adder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        long_fmt = 1'b0, norm_en = 1'b0, cmp_only = 1'b0, sub_b = 1'b0;
   logic [31:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
   logic        busy, done, res_wr, exp_ovf, exp_unf;
   logic [31:0] res_hi, res_lo;
   logic [1:0]  cc;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   logic [31:0] last_hi = '0, last_lo = '0;
   logic [31:0] x_hi, x_lo;
   logic [1:0]  x_cc;
   logic        x_ovf, x_unf;

   always #4 clk = ~clk;

   hex_fp_adder u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .long_fmt(long_fmt),
      .norm_en(norm_en), .cmp_only(cmp_only), .sub_b(sub_b),
      .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
      .busy(busy), .done(done), .res_wr(res_wr), .res_hi(res_hi),
      .res_lo(res_lo), .cc(cc), .exp_ovf(exp_ovf), .exp_unf(exp_unf)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Reference computed from the requirements
   task automatic model(input logic [31:0] ahi, alo, bhi, blo,
                        input logic lng, nrm, cmp, sub);
      logic [63:0] ma, mb, m, keep;
      int ea, eb, e;
      logic sa, sb, s;
      keep = lng ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_0000_0000;
      ma = {4'h0, ahi[23:0], (lng ? alo : 32'h0), 4'h0};
      mb = {4'h0, bhi[23:0], (lng ? blo : 32'h0), 4'h0};
      ea = int'(ahi[30:24]);
      eb = int'(bhi[30:24]);
      sa = ahi[31];
      sb = bhi[31] ^ sub;
      while (ea < eb) begin ma = (ma >> 4) & keep; ea++; end
      while (eb < ea) begin mb = (mb >> 4) & keep; eb++; end
      e = ea;
      if (sa == sb)      begin m = ma + mb; s = sa; end
      else if (mb >= ma) begin m = mb - ma; s = sb; end
      else               begin m = ma - mb; s = sa; end
      x_cc  = (m == 0) ? 2'd0 : (s ? 2'd1 : 2'd2);
      x_ovf = 1'b0;
      x_unf = 1'b0;
      if (m[63:60] != 4'h0) begin
         m = (m >> 4) & keep;
         if (e == 127) begin e = 0; x_ovf = 1'b1; end else e++;
      end else if (nrm) begin
         while (m != 0 && m[59:56] == 4'h0) begin
            m = m << 4;
            if (e == 0) begin e = 127; x_unf = 1'b1; end else e--;
         end
      end
      if (cmp) begin
         x_hi = last_hi; x_lo = last_lo; x_ovf = 1'b0; x_unf = 1'b0;
      end else begin
         x_hi = {s, e[6:0], m[59:36]};
         x_lo = lng ? m[35:4] : 32'h0;
      end
   endtask

   task automatic run_op(input logic [31:0] ahi, alo, bhi, blo,
                         input logic lng, nrm, cmp, sub,
                         input string tag, input bit disturb);
      int n;
      model(ahi, alo, bhi, blo, lng, nrm, cmp, sub);
      @(negedge clk);
      a_hi = ahi; a_lo = alo; b_hi = bhi; b_lo = blo;
      long_fmt = lng; norm_en = nrm; cmp_only = cmp; sub_b = sub;
      start = 1'b1;
      @(negedge clk);
      if (disturb) begin
         a_hi = 32'h4A123456; b_hi = 32'hC1777777; sub_b = ~sub;
         cmp_only = ~cmp; norm_en = ~nrm;
         @(negedge clk);
      end
      start = 1'b0;
      n = 0;
      while (!done && n < 1000) begin @(negedge clk); n++; end
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL %s done: actual 0 expected 1 (timeout)", tag);
      end
      check(tag, "res_hi", res_hi, x_hi);
      check(tag, "res_lo", res_lo, x_lo);
      check(tag, "cc", {30'd0, cc}, {30'd0, x_cc});
      check(tag, "exp_ovf", {31'd0, exp_ovf}, {31'd0, x_ovf});
      check(tag, "exp_unf", {31'd0, exp_unf}, {31'd0, x_unf});
      check(tag, "res_wr", {31'd0, res_wr}, {31'd0, ~cmp});
      last_hi = x_hi; last_lo = x_lo;
      @(negedge clk);
      check(tag, "done pulse R9", {31'd0, done}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual expired expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11", "busy", {31'd0, busy}, 32'd0);
      check("R11", "done", {31'd0, done}, 32'd0);
      check("R11", "res_hi", res_hi, 32'd0);
      check("R11", "res_lo", res_lo, 32'd0);
      check("R11", "cc", {30'd0, cc}, 32'd0);
      check("R11", "flags", {30'd0, exp_ovf, exp_unf}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: like signs, simple and carry cases
      run_op(32'h41100000, 0, 32'h41200000, 0, 0, 1, 0, 0, "R3 plain", 0);
      run_op(32'h41F00000, 0, 32'h41900000, 0, 0, 1, 0, 0, "R3 carry", 0);
      // R4: unlike signs, both orderings and exact cancellation
      run_op(32'h42300000, 0, 32'hC2100000, 0, 0, 1, 0, 0, "R4 a_big", 0);
      run_op(32'h42100000, 0, 32'hC2300000, 0, 0, 1, 0, 0, "R4 b_big", 0);
      run_op(32'hC1500000, 0, 32'h41500000, 0, 0, 1, 0, 0, "R4 cancel", 0);
      run_op(32'h41500000, 0, 32'h41500000, 0, 0, 1, 0, 1, "R4 sub_b", 0);
      // R2: alignment across many digits, beyond the guard digit
      run_op(32'h44123456, 0, 32'h40FFFFFF, 0, 0, 0, 0, 0, "R2 far", 0);
      run_op(32'h10ABCDEF, 0, 32'h12000001, 0, 0, 0, 0, 0, "R2 near", 0);
      // R10: guard digit participates and is then dropped
      run_op(32'h41100000, 0, 32'hC0000001, 0, 0, 1, 0, 0, "R10 guard", 0);
      run_op(32'h41100000, 0, 32'hC0000001, 0, 0, 0, 0, 0, "R10 unnorm", 0);
      // R1: long format, and short format ignoring low words
      run_op(32'h41123456, 32'h789ABCDE, 32'h40F00000, 32'h00000011, 1, 1, 0, 0, "R1 long", 0);
      run_op(32'h41123456, 32'h789ABCDE, 32'h40F00000, 32'h00000011, 0, 1, 0, 0, "R1 short", 0);
      // R7: unnormalized keeps leading zeros, normalized removes them
      run_op(32'h45000123, 0, 32'h45000001, 0, 0, 0, 0, 0, "R7 unnorm", 0);
      run_op(32'h45000123, 0, 32'h45000001, 0, 0, 1, 0, 0, "R7 norm", 0);
      run_op(32'h45000000, 0, 32'h45000000, 0, 0, 1, 0, 0, "R7 zero", 0);
      // R8: overflow and underflow wrap
      run_op(32'h7FF00000, 0, 32'h7FF00000, 0, 0, 1, 0, 0, "R8 ovf", 0);
      run_op(32'h00010000, 0, 32'h00000000, 0, 0, 1, 0, 0, "R8 unf", 0);
      // R5 and R6: compare mode, result held
      run_op(32'hC3100000, 0, 32'h42100000, 0, 0, 1, 1, 0, "R6 cmp neg R5", 0);
      run_op(32'h42100000, 0, 32'h42100000, 0, 0, 1, 1, 1, "R6 cmp eq R5", 0);
      // R9: start while busy is ignored
      run_op(32'h10300000, 0, 32'h50200000, 0, 0, 1, 0, 0, "R9 busy", 1);

      // R2 R3 R4 R5: constrained random
      for (int i = 0; i < 300; i++) begin
         logic [31:0] ra, rb, rla, rlb;
         logic [6:0]  eb7;
         ra  = $urandom;
         rb  = $urandom;
         rla = $urandom;
         rlb = $urandom;
         if ((i % 4) != 0) begin
            eb7 = ra[30:24] + 7'($urandom_range(0, 8)) - 7'd4;
            rb[30:24] = eb7;
         end
         if ((i % 7) == 0) rb[23:0] = ra[23:0];
         if ((i % 5) == 0) ra[23:20] = 4'h0;
         run_op(ra, rla, rb, rlb, 1'($urandom), 1'($urandom),
                ((i % 9) == 0), 1'($urandom), "R2 random", 0);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule